// File: doc/BRIEF.md
# RAM-Backed Fixed Delay Line

This block delays a stream of multi-bit samples by a fixed number of accepted samples. The samples are kept in a small RAM, not in a chain of registers. Two address counters step around that RAM, and the samples never move once written. Each clock with the shift-enable high accepts one input sample, writes it at the write address and reads the oldest stored sample into the output register. Each cycle only the two addresses change, not every stored bit. This makes long delays cheap in area and switching power.

Users set the sample width and the RAM depth as parameters. A third parameter picks one of two ways to give a defined zero output while the line is still filling after reset. In the first, a fill counter masks unwritten reads. In the second, every RAM word is cleared on reset. Both give the same behaviour at the ports.

Top module: `ram_delay_line`

## Requirements
- R1: While `rst` is high at a rising edge, `dout` becomes 0. The read address is set to entry 0 and the write address to entry DEPTH-1.
- R2: On each enabled edge, both addresses advance by one and wrap from DEPTH-1 to 0. The write address always equals the read address minus one, modulo DEPTH. Data keeps its correct order across many wraps.
- R3: Count enabled edges from the last reset as k = 1, 2, … For k ≥ DEPTH, `dout` after the k-th enabled edge equals the `din` accepted at enabled edge k-DEPTH+1.
- R4: For k < DEPTH enabled edges after reset, `dout` is 0.
- R5: When `shift_en` is low, `dout` and both addresses hold their values and `din` is ignored. Samples presented on non-enabled cycles never appear at the output.
- R6: A reset in mid-stream discards the stored history. The first DEPTH-1 enabled edges after it give 0 on `dout`, even though the RAM still holds older data.
- R7: Both storage variants give identical `dout` sequences for the same inputs: masking unwritten reads with a fill counter, or clearing the RAM on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Accept one sample and advance the line this cycle |
| din | input | DATA_W | Sample entering the line |
| dout | output | DATA_W | Registered sample leaving the line |

## Verification
The main test is a counting ramp run for several full turns of the RAM. Each output value then names the entry it came from. A wrong address offset, a missed wrap or a wrong initial pointer shows up as a specific wrong number, not just a mismatch. Bursts with enable low and junk on `din` follow. These separate a line that holds correctly from one that leaks non-enabled samples or advances anyway. Seeded random enable patterns with random data then run against two instances, one of each storage variant. A reset in mid-stream, with the RAM full of nonzero data, shows whether the fill-phase zeros come from real masking or only from the RAM's power-up contents.

// File: rtl/dly_pkg.sv
package dly_pkg;

   // How unwritten RAM words are kept out of the output after reset.
   typedef enum logic {
      STORE_MASKED  = 1'b0,   // fill counter forces zero until primed
      STORE_CLEARED = 1'b1    // every RAM word is zeroed by reset
   } store_mode_e;

   // Address width for a RAM of the given depth (at least one bit).
   function automatic int unsigned addr_bits(input int unsigned depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/dly_ptr.sv
module dly_ptr #(
   parameter int unsigned   DEPTH = 16,
   parameter int unsigned   AW    = 4,
   parameter logic [AW-1:0] START = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

   logic [AW-1:0] nxt;

   always_comb begin
      nxt = (ptr == TOP) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)
         ptr <= START;
      else if (adv)
         ptr <= nxt;
   end
endmodule

// File: rtl/dly_fill.sv
module dly_fill #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   output logic primed
);
   localparam logic [AW-1:0] GOAL = AW'(DEPTH - 1);

   logic [AW-1:0] seen;

   // High once DEPTH-1 enabled cycles have passed: from then on the read
   // address only lands on entries that were written since reset.
   assign primed = (seen == GOAL);

   always_ff @(posedge clk) begin
      if (rst)
         seen <= '0;
      else if (adv && !primed)
         seen <= seen + 1'b1;
   end
endmodule

// File: rtl/dly_store.sv
module dly_store #(
   parameter int unsigned          DATA_W = 8,
   parameter int unsigned          DEPTH  = 16,
   parameter int unsigned          AW     = 4,
   parameter dly_pkg::store_mode_e MODE   = dly_pkg::STORE_MASKED
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   input  logic              primed,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] word;

   generate
      if (MODE == dly_pkg::STORE_CLEARED) begin : g_cleared
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < int'(DEPTH); i++)
                  mem[i] <= '0;
            end else if (en) begin
               mem[wr_addr] <= wr_data;
            end
         end
      end else begin : g_masked
         always_ff @(posedge clk) begin
            if (en)
               mem[wr_addr] <= wr_data;
         end
      end
   endgenerate

   // Read and write addresses differ on every cycle, so there is no
   // same-address collision to resolve.
   always_comb begin
      word = primed ? mem[rd_addr] : '0;
   end

   always_ff @(posedge clk) begin
      if (rst)
         rd_data <= '0;
      else if (en)
         rd_data <= word;
   end
endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line #(
   parameter int unsigned          DATA_W = 8,
   parameter int unsigned          DEPTH  = 16,
   parameter dly_pkg::store_mode_e MODE   = dly_pkg::STORE_MASKED
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int unsigned   AW    = dly_pkg::addr_bits(DEPTH);
   localparam logic [AW-1:0] FIRST = '0;
   localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ram_delay_line: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("ram_delay_line: DATA_W must be at least 1");
      end
   endgenerate

   logic [AW-1:0] rd_ptr;
   logic [AW-1:0] wr_ptr;
   logic          primed;

   dly_ptr #(.DEPTH(DEPTH), .AW(AW), .START(FIRST)) u_rd_ptr (
      .clk (clk),
      .rst (rst),
      .adv (shift_en),
      .ptr (rd_ptr)
   );

   dly_ptr #(.DEPTH(DEPTH), .AW(AW), .START(LAST)) u_wr_ptr (
      .clk (clk),
      .rst (rst),
      .adv (shift_en),
      .ptr (wr_ptr)
   );

   generate
      if (MODE == dly_pkg::STORE_MASKED) begin : g_fill
         dly_fill #(.DEPTH(DEPTH), .AW(AW)) u_fill (
            .clk    (clk),
            .rst    (rst),
            .adv    (shift_en),
            .primed (primed)
         );
      end else begin : g_nofill
         assign primed = 1'b1;
      end
   endgenerate

   dly_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .MODE(MODE)) u_store (
      .clk     (clk),
      .rst     (rst),
      .en      (shift_en),
      .wr_addr (wr_ptr),
      .wr_data (din),
      .rd_addr (rd_ptr),
      .primed  (primed),
      .rd_data (dout)
   );
endmodule

// File: rtl/dly_chk.sv
module dly_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned AW     = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              shift_en,
   input logic [DATA_W-1:0] dout,
   input logic [AW-1:0]     rd_ptr,
   input logic [AW-1:0]     wr_ptr
);
   localparam logic [AW-1:0] TOP  = AW'(DEPTH - 1);
   localparam logic [AW:0]   FILL = (AW+1)'(DEPTH - 1);

   logic [AW:0] steps;
   logic        spacing_ok;

   always_ff @(posedge clk) begin
      if (rst)
         steps <= '0;
      else if (shift_en && steps < FILL)
         steps <= steps + 1'b1;
   end

   always_comb begin
      spacing_ok = (rd_ptr == '0) ? (wr_ptr == TOP) : (wr_ptr == rd_ptr - 1'b1);
   end

   p_reset_state_r1: assert property (@(posedge clk)
      rst |=> (rd_ptr == '0 && wr_ptr == TOP && dout == '0));

   p_ptr_spacing_r2: assert property (@(posedge clk) disable iff (rst)
      spacing_ok);

   p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (rst)
      (shift_en && rd_ptr == TOP) |=> (rd_ptr == '0));

   p_fill_zero_r4: assert property (@(posedge clk) disable iff (rst)
      (shift_en && steps < FILL) |=> (dout == '0));

   p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> ($stable(dout) && $stable(rd_ptr) && $stable(wr_ptr)));
endmodule

bind ram_delay_line dly_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .shift_en (shift_en),
   .dout     (dout),
   .rd_ptr   (rd_ptr),
   .wr_ptr   (wr_ptr)
);

// File: tb/ram_delay_line_test.sv
module ram_delay_line_test;
   localparam int unsigned W = 8;
   localparam int unsigned N = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         shift_en = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] dout_a;
   logic [W-1:0] dout_b;

   int tests = 0;
   int fails = 0;
   int kcnt = 0;
   bit after_rerst = 1'b0;
   logic [W-1:0] exp_q = '0;
   logic [W-1:0] hist [0:4095];

   always #10 clk = ~clk;   // 50 MHz

   ram_delay_line #(.DATA_W(W), .DEPTH(N), .MODE(dly_pkg::STORE_MASKED)) uut (
      .clk(clk), .rst(rst), .shift_en(shift_en), .din(din), .dout(dout_a));

   ram_delay_line #(.DATA_W(W), .DEPTH(N), .MODE(dly_pkg::STORE_CLEARED)) uut_clr (
      .clk(clk), .rst(rst), .shift_en(shift_en), .din(din), .dout(dout_b));

   function automatic logic [W-1:0] model_out(input int k);
      return (k >= int'(N)) ? hist[k - int'(N) + 1] : '0;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: dout=%0h expected %0h (k=%0d)", tag, got, exp, kcnt);
      end
   endtask

   task automatic tick(input logic r, input logic e, input logic [W-1:0] d);
      string tag;
      rst = r; shift_en = e; din = d;
      @(posedge clk);
      #2;
      if (r) begin
         kcnt = 0; exp_q = '0; tag = "R1";
      end else if (e) begin
         kcnt++;
         hist[kcnt] = d;
         exp_q = model_out(kcnt);
         if (kcnt < int'(N))          tag = after_rerst ? "R6" : "R4";
         else if (kcnt >= 2*int'(N))  tag = "R2";
         else                         tag = "R3";
      end else begin
         tag = "R5";
      end
      check(tag, dout_a, exp_q);
      check("R7", dout_b, exp_q);
   endtask

   initial begin
      void'($urandom(32'd4242));
      // R1: reset state
      repeat (3) tick(1'b1, 1'b0, 8'hFF);
      // R4, R3, R2: counting ramp over several RAM turns
      for (int i = 1; i <= 4*int'(N); i++) tick(1'b0, 1'b1, W'(i));
      // R5: enable low with junk data, then resume
      for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, 8'hA5 ^ W'(i));
      for (int i = 0; i < 2*int'(N); i++) tick(1'b0, 1'b1, W'(8'h40 + i));
      // Random enable and data
      for (int i = 0; i < 600; i++)
         tick(1'b0, (($urandom % 10) < 7), W'($urandom));
      // R6: reset in mid-stream with a full RAM
      tick(1'b1, 1'b1, 8'h11);
      after_rerst = 1'b1;
      for (int i = 0; i < 3*int'(N); i++) tick(1'b0, 1'b1, W'(8'hC0 + i));
      for (int i = 0; i < 300; i++)
         tick(1'b0, (($urandom % 10) < 5), W'($urandom));
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule